// File: doc/BRIEF.md
# Chainable FIFO Stage with Token Handoff

This block is the control and storage of one FIFO stage. Several identical stages can be joined in a ring to make a deeper buffer. All stages share the write strobe, the write data and the read strobe. Each stage keeps a write token and a read token. A stage stores a word only while it holds the write token, and it returns a word only while it holds the read token. When a stage handles the access to its own last location, it drives a one-cycle handoff pulse. The next stage in the ring picks up the token on that pulse. The write and read tokens travel independently, each on its own pulse line. A static first-load strap picks the stage that holds both tokens after reset. The system around the ring forms the combined flags: the ring is empty only when every stage is empty, and full only when every stage is full.

A stage can also work on its own. With the solo strap set, it always holds both tokens and ignores its handoff inputs. Its write handoff output then carries a half-full level, and a rewind input replays the stored data from location zero. Rewind and half-full are inactive when stages are chained.

Top module: `chain_fifo_stage`

## Requirements
- R1: After reset every stage reports empty_o=1 and full_o=0, drives both handoff outputs low and has rvalid_o=0. The first write then lands only in the stage whose first_i is 1.
- R2: A write (wr_i=1 at a rising edge) is stored only if the stage holds the write token and full_o=0. Otherwise it is ignored. full_o=1 exactly when the stage holds DEPTH unread words.
- R3: A read (rd_i=1 at a rising edge) is served only if the stage holds the read token and empty_o=0. The word appears on rdata_o with rvalid_o=1 in the cycle after that edge. An ignored read leaves rvalid_o=0.
- R4: Words leave the ring in the order they were written, including across stage boundaries.
- R5: In the same cycle that a chained stage accepts a write to its last location (address DEPTH-1), xout_wr_o is 1. It is 1 for that cycle only and the stage gives up the write token. A stage that sees xin_wr_i=1 at an edge holds the write token from that edge on, so the next write goes into the next stage without a gap.
- R6: Read handoff works the same way through xout_rd_o and xin_rd_i, on an accepted read of address DEPTH-1.
- R7: For a ring of three stages with DEPTH=8, the AND of all empty_o is 1 exactly when no word is stored. The AND of all full_o is 1 exactly after 24 unread writes.
- R8: In chained mode (solo_i=0), rewind_i has no effect, and xout_wr_o stays low whenever no last-location write is happening, whatever the fill level.
- R9: With solo_i=1, the stage holds both tokens whatever first_i is, ignores xin_wr_i and xin_rd_i, and keeps xout_rd_o at 0.
- R10: With solo_i=1, xout_wr_o is 1 exactly when the stage holds more than DEPTH/2 words.
- R11: With solo_i=1, rewind_i=1 at an edge moves the read pointer to location 0 and leaves the write pointer unchanged. After up to DEPTH writes since reset, the stored words are replayed from the first one. A read in the same cycle as a rewind is ignored.
- R12: A write and a read in the same cycle are both carried out, even when each hands off its token in that cycle, and in different stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| solo_i | input | 1 | Static strap: 1 = stand-alone stage, 0 = member of a ring |
| first_i | input | 1 | Static strap: 1 = this stage holds both tokens after reset |
| rewind_i | input | 1 | Stand-alone only: restart reading from location 0 |
| wr_i | input | 1 | Write strobe shared by the ring |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe shared by the ring |
| rdata_o | output | DATA_W | Read data, valid while rvalid_o is 1 |
| rvalid_o | output | 1 | One cycle after a served read |
| empty_o | output | 1 | Stage holds no unread word |
| full_o | output | 1 | Stage holds DEPTH unread words |
| xin_wr_i | input | 1 | Write-token handoff from the previous stage |
| xin_rd_i | input | 1 | Read-token handoff from the previous stage |
| xout_wr_o | output | 1 | Write-token handoff to the next stage; half-full level in stand-alone use |
| xout_rd_o | output | 1 | Read-token handoff to the next stage |

## Verification
The two functions that can land in the same cycle are the write-token handoff and the read-token handoff. They can also happen in different stages. The bench sets this up on a three-stage ring. It fills the first stage and seven words of the second, then drains seven words from the first. Next it raises write and read together for one cycle. In that cycle the second stage must pulse its write handoff and the first stage its read handoff. The read must return the first stage's last word. After that, the next write has to land in the third stage and the remaining reads have to come out in write order.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  // Which side of the stage a pointer unit serves; the read side alone
  // honours the rewind request.
  typedef enum logic {
    SIDE_WR = 1'b0,
    SIDE_RD = 1'b1
  } side_e;

endpackage

// File: rtl/chain_fifo_rst_sync.sv
module chain_fifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/chain_fifo_ptr.sv
module chain_fifo_ptr
  import chain_fifo_pkg::*;
#(
  parameter int    AW   = 3,
  parameter side_e SIDE = SIDE_WR
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        solo_i,
  input  logic        first_i,
  input  logic        req_i,
  input  logic        block_i,
  input  logic        rewind_i,
  input  logic        xin_i,
  output logic [AW:0] ptr_o,
  output logic        tok_o,
  output logic        fire_o,
  output logic        xout_o
);

  localparam logic [AW:0] PTR_ONE = (AW+1)'(1);

  logic          flip_q, flip_d;
  logic [AW:0]   ptr_q, ptr_d;
  logic          at_last;
  logic          rewind_eff;
  logic          ptr_en;

  // Token state is kept relative to the first-load strap so that the
  // register itself resets to a constant.
  assign tok_o      = solo_i | (first_i ^ flip_q);
  assign rewind_eff = (SIDE == SIDE_RD) & rewind_i & solo_i;
  assign at_last    = &ptr_q[AW-1:0];
  assign fire_o     = req_i & tok_o & ~block_i & ~rewind_eff;
  assign xout_o     = fire_o & at_last & ~solo_i;
  assign ptr_en     = fire_o | rewind_eff;
  assign ptr_o      = ptr_q;

  always_comb begin
    flip_d = flip_q;
    if (!solo_i) begin
      if (xin_i) begin
        flip_d = ~first_i;
      end else if (xout_o) begin
        flip_d = first_i;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (rewind_eff) begin
      ptr_d = '0;
    end else if (fire_o) begin
      ptr_d = ptr_q + PTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q <= 1'b0;
    end else begin
      flip_q <= flip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // R5 (and R6 on the read side): a handoff gives the token away
  assert_pass_drops_token_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (xout_o && !xin_i) |=> !tok_o);

  // R5 (and R6 on the read side): an incoming handoff grants the token
  assert_take_token_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!solo_i && xin_i) |=> tok_o);

endmodule

// File: rtl/chain_fifo_store.sv
module chain_fifo_store #(
  parameter int W  = 9,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  output logic          rvalid_o
);

  localparam int ROWS = 1 << AW;

  logic [W-1:0] mem [ROWS];
  logic [W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_d = mem[raddr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (re_i) begin
      rdata_o <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
    end
  end

endmodule

// File: rtl/chain_fifo_stage.sv
module chain_fifo_stage
  import chain_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              solo_i,
  input  logic              first_i,
  input  logic              rewind_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              empty_o,
  output logic              full_o,
  input  logic              xin_wr_i,
  input  logic              xin_rd_i,
  output logic              xout_wr_o,
  output logic              xout_rd_o
);

  localparam int          AW       = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  logic          rst_s_n;
  logic [AW:0]   w_ptr, r_ptr, fill;
  logic          w_tok, r_tok;
  logic          w_fire, r_fire;
  logic          w_pass, r_pass;
  logic          half;

  chain_fifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  chain_fifo_ptr #(.AW(AW), .SIDE(SIDE_WR)) u_wptr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .solo_i   (solo_i),
    .first_i  (first_i),
    .req_i    (wr_i),
    .block_i  (full_o),
    .rewind_i (1'b0),
    .xin_i    (xin_wr_i),
    .ptr_o    (w_ptr),
    .tok_o    (w_tok),
    .fire_o   (w_fire),
    .xout_o   (w_pass)
  );

  chain_fifo_ptr #(.AW(AW), .SIDE(SIDE_RD)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .solo_i   (solo_i),
    .first_i  (first_i),
    .req_i    (rd_i),
    .block_i  (empty_o),
    .rewind_i (rewind_i),
    .xin_i    (xin_rd_i),
    .ptr_o    (r_ptr),
    .tok_o    (r_tok),
    .fire_o   (r_fire),
    .xout_o   (r_pass)
  );

  chain_fifo_store #(.W(DATA_W), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .we_i     (w_fire),
    .waddr_i  (w_ptr[AW-1:0]),
    .wdata_i  (wdata_i),
    .re_i     (r_fire),
    .raddr_i  (r_ptr[AW-1:0]),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // Occupancy from the extended pointers: the extra top bit tells a
  // wrapped full stage from an empty one.
  assign fill    = w_ptr - r_ptr;
  assign empty_o = (fill == '0);
  assign full_o  = (fill == FULL_CNT);
  assign half    = (fill > HALF_CNT);

  assign xout_wr_o = solo_i ? half : w_pass;
  assign xout_rd_o = solo_i ? 1'b0 : r_pass;

  assert_no_overflow_R2 : assert property (@(posedge clk) disable iff (!rst_s_n)
    fill <= FULL_CNT);

  assert_read_blocked_R3 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && empty_o) |=> !rvalid_o);

  assert_token_served_R3 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && !r_tok) |=> !rvalid_o);

  assert_rewind_keeps_wptr_R11 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (solo_i && rewind_i && !(wr_i && w_tok)) |=> $stable(w_ptr));

  assert_rewind_restarts_R11 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (solo_i && rewind_i) |=> (r_ptr == '0));

  assert_solo_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_s_n)
    solo_i |-> !xout_rd_o);

endmodule

// File: tb/chain_fifo_stage_bench.sv
module chain_fifo_stage_bench;

  localparam int N  = 3;
  localparam int DW = 9;
  localparam int DP = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr, rd, rw;
  logic [DW-1:0] wdata;
  logic [N-1:0] emp, ful, rv, xw, xr;
  logic [DW-1:0] rdat [N];
  logic [DW-1:0] c_rdat;
  logic c_rv, c_empty, c_full;

  logic s_wr, s_rd, s_rw, s_xw_in, s_xr_in;
  logic [DW-1:0] s_wdata, s_rdat;
  logic s_rv, s_emp, s_ful, s_xw, s_xr;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] q[$];

  always #10 clk = ~clk;

  for (genvar k = 0; k < N; k++) begin : g_st
    localparam int PREV = (k + N - 1) % N;
    chain_fifo_stage #(.DATA_W(DW), .DEPTH(DP)) u_chain_fifo_stage (
      .clk(clk), .rst_n(rst_n), .solo_i(1'b0), .first_i(k == 0),
      .rewind_i(rw), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
      .rdata_o(rdat[k]), .rvalid_o(rv[k]), .empty_o(emp[k]), .full_o(ful[k]),
      .xin_wr_i(xw[PREV]), .xin_rd_i(xr[PREV]),
      .xout_wr_o(xw[k]), .xout_rd_o(xr[k]));
  end

  chain_fifo_stage #(.DATA_W(DW), .DEPTH(DP)) u_chain_fifo_stage_solo (
    .clk(clk), .rst_n(rst_n), .solo_i(1'b1), .first_i(1'b0),
    .rewind_i(s_rw), .wr_i(s_wr), .wdata_i(s_wdata), .rd_i(s_rd),
    .rdata_o(s_rdat), .rvalid_o(s_rv), .empty_o(s_emp), .full_o(s_ful),
    .xin_wr_i(s_xw_in), .xin_rd_i(s_xr_in),
    .xout_wr_o(s_xw), .xout_rd_o(s_xr));

  always_comb begin
    c_rdat = '0;
    for (int k = 0; k < N; k++) if (rv[k]) c_rdat = c_rdat | rdat[k];
  end
  assign c_rv    = |rv;
  assign c_empty = &emp;
  assign c_full  = &ful;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Chain write; exp_xw < 0 skips the handoff check.
  task automatic ch_push(input logic [DW-1:0] v, input int exp_xw);
    @(negedge clk);
    wr = 1'b1; wdata = v;
    #1;
    if (exp_xw >= 0) chk("R5 write handoff", int'(xw), exp_xw);
    @(negedge clk);
    wr = 1'b0;
    if (q.size() < N * DP) q.push_back(v);
  endtask

  task automatic ch_pop(input string tag, input int exp_xr);
    logic [DW-1:0] e;
    @(negedge clk);
    rd = 1'b1;
    #1;
    if (exp_xr >= 0) chk("R6 read handoff", int'(xr), exp_xr);
    @(negedge clk);
    rd = 1'b0;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(tag, int'(c_rv), 1);
      chk(tag, int'(c_rdat), int'(e));
    end else begin
      chk(tag, int'(c_rv), 0);
    end
  endtask

  task automatic s_push(input logic [DW-1:0] v);
    @(negedge clk);
    s_wr = 1'b1; s_wdata = v;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic s_pop(input string tag, input int exp);
    @(negedge clk);
    s_rd = 1'b1;
    @(negedge clk);
    s_rd = 1'b0;
    chk(tag, int'(s_rv), 1);
    chk(tag, int'(s_rdat), exp);
  endtask

  task automatic t_reset();
    chk("R1 empty flags", int'(emp), 7);
    chk("R1 full flags", int'(ful), 0);
    chk("R1 write handoff idle", int'(xw), 0);
    chk("R1 read handoff idle", int'(xr), 0);
    chk("R1 rvalid idle", int'(rv), 0);
    chk("R1 solo empty", int'(s_emp), 1);
    chk("R1 solo full", int'(s_ful), 0);
  endtask

  task automatic t_first_owner();
    ch_push(9'h011, 0);
    chk("R1 first write lands in first-load stage", int'(emp), 3'b110);
  endtask

  task automatic t_fill();
    for (int i = 1; i < N * DP; i++) begin
      ch_push(DW'(i * 37 + 5), (i % DP == DP - 1) ? (1 << (i / DP)) : 0);
      if (i == DP - 1) begin
        chk("R2 stage full after DEPTH writes", int'(ful), 3'b001);
        chk("R5 next stage still empty", int'(emp), 3'b110);
      end
      if (i == DP) chk("R5 write continues in next stage", int'(emp), 3'b100);
    end
    chk("R7 composite full", int'(c_full), 1);
    chk("R7 composite not empty", int'(c_empty), 0);
    ch_push(9'h1FF, 0);
    chk("R2 write to full ring ignored", int'(ful), 7);
  endtask

  task automatic t_drain();
    for (int i = 0; i < N * DP; i++) begin
      ch_pop("R4 order across stages", (i % DP == DP - 1) ? (1 << (i / DP)) : 0);
      if (i == 0) chk("R7 composite full clears", int'(c_full), 0);
    end
    chk("R7 composite empty", int'(c_empty), 1);
    ch_pop("R3 read of empty ring ignored", -1);
  endtask

  task automatic t_both_handoffs();
    logic [DW-1:0] e;
    for (int i = 0; i < 2 * DP - 1; i++) ch_push(DW'(200 + i), -1);
    for (int i = 0; i < DP - 1; i++) ch_pop("R4 partial drain", -1);
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; wdata = 9'h0AB;
    #1;
    chk("R12 write handoff from second stage", int'(xw), 3'b010);
    chk("R12 read handoff from first stage", int'(xr), 3'b001);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    e = q.pop_front();
    q.push_back(9'h0AB);
    chk("R12 read served", int'(c_rv), 1);
    chk("R12 read data", int'(c_rdat), int'(e));
    ch_push(9'h0CD, 0);
    chk("R12 next write in third stage", int'(emp), 3'b001);
    for (int i = 0; i < DP + 1; i++)
      ch_pop("R12 order after double handoff", (i == DP - 1) ? 3'b010 : 0);
    chk("R12 ring empty again", int'(c_empty), 1);
  endtask

  task automatic t_chain_rewind();
    @(negedge clk);
    rw = 1'b1;
    @(negedge clk);
    rw = 1'b0;
    chk("R8 rewind ignored in chain", int'(emp), 7);
    for (int i = 0; i < DP / 2 + 1; i++) ch_push(DW'(300 + i), 0);
    @(negedge clk);
    chk("R8 no half-full level in chain", int'(xw), 0);
    for (int i = 0; i < DP / 2 + 1; i++) ch_pop("R8 data after ignored rewind", -1);
  endtask

  task automatic t_solo();
    @(negedge clk);
    s_xw_in = 1'b1; s_xr_in = 1'b1;
    @(negedge clk);
    s_xw_in = 1'b0; s_xr_in = 1'b0;
    for (int i = 0; i < DP / 2; i++) s_push(DW'(50 + i));
    chk("R10 half-full low at DEPTH/2", int'(s_xw), 0);
    chk("R9 solo read handoff low", int'(s_xr), 0);
    s_push(DW'(54));
    chk("R10 half-full high above DEPTH/2", int'(s_xw), 1);
    s_pop("R9 solo owns read token", 50);
    s_pop("R9 solo second read", 51);
    @(negedge clk);
    s_rw = 1'b1; s_rd = 1'b1;
    @(negedge clk);
    s_rw = 1'b0; s_rd = 1'b0;
    chk("R11 read with rewind ignored", int'(s_rv), 0);
    chk("R11 level after rewind", int'(s_xw), 1);
    for (int i = 0; i < 5; i++) s_pop("R11 replay from start", 50 + i);
    chk("R11 empty after replay", int'(s_emp), 1);
    for (int i = 0; i < DP; i++) s_push(DW'(80 + i));
    chk("R2 solo full", int'(s_ful), 1);
    s_push(DW'(99));
    chk("R2 solo still full", int'(s_ful), 1);
    s_pop("R2 write to full stage ignored", 80);
    chk("R9 solo read handoff stays low", int'(s_xr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; rw = 1'b0; wdata = '0;
    s_wr = 1'b0; s_rd = 1'b0; s_rw = 1'b0; s_wdata = '0;
    s_xw_in = 1'b0; s_xr_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_owner();
    t_fill();
    t_drain();
    t_both_handoffs();
    t_chain_rewind();
    t_solo();
    report();
    $finish;
  end

endmodule